// File: doc/BRIEF.md
# I2C Target Byte-Protocol Controller

This block answers as a target on a two-wire I2C bus at one fixed 7-bit address. It watches the clock and data lines with the system clock and finds the start and stop conditions. It collects the address byte, decides from its last bit whether the controller on the bus wants to write or read, and then acknowledges or declines each byte. During reads it also samples the acknowledge bit that the bus controller returns.

Received bytes go to a downstream buffer through a one-cycle write strobe. The block tracks how full that buffer is during the current transfer. Transmit bytes come from an upstream source that holds `tx_valid` high while it has a byte ready; the block pulses `tx_ready` on the cycle it takes `tx_data`. When a transfer closes, the block emits a done pulse that carries the number of bytes moved. The data output is open-drain: `sda_oe` high means the block pulls the data line low.

Top module: `i2c_target_ctrl`

## Requirements
- R1: During and just after reset, `sda_oe`, `rx_valid`, `tx_ready`, `rx_done` and `tx_done` are all 0.
- R2: An address byte of 0x84 (address 0x42, direction bit 0) is acknowledged. Each following byte is acknowledged and presented once on `rx_valid`/`rx_data`, assembled MSB first.
- R3: An address byte whose upper seven bits are not 0x42 and which is not 0x00 is not acknowledged. The data line is never driven and nothing is received until the next start.
- R4: An address byte of 0x00 (general call) is acknowledged. The byte after it is not acknowledged and produces no `rx_valid`.
- R5: The address byte 0x85 (address 0x42, direction bit 1) is acknowledged when `tx_valid` is high. The block takes a byte with a `tx_ready` pulse and shifts it out MSB first, a 0 bit by asserting `sda_oe`.
- R6: The address byte 0x85 is not acknowledged when `tx_valid` is low, and no byte is taken.
- R7: After a byte that the bus controller acknowledges, the block takes the next transmit byte. If none is available, it leaves the data line released, so the bus controller reads 0xFF.
- R8: When the bus controller does not acknowledge a transmitted byte, the block releases the line. If at least one byte was acknowledged, it pulses `tx_done` with `tx_done_count` equal to the number of acknowledged bytes.
- R9: At most RX_DEPTH (25) bytes are accepted per transfer. The next byte is not acknowledged, gives no `rx_valid`, and pulses `rx_done` with a count of RX_DEPTH.
- R10: A start (including a repeated start) or a stop closes out a pending transfer. It pulses `rx_done` and/or `tx_done` with the counts that have built up, when those are nonzero.
- R11: A stop, even one that comes straight after a start with no clock pulse, releases the line and returns the block to waiting. The next address is handled normally.
- R12: `sda_oe` changes only in the cycle after a detected SCL falling edge, start or stop. It never changes while SCL is steadily high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired value) |
| sda_oe | output | 1 | 1 pulls the data line low |
| rx_valid | output | 1 | One-cycle strobe: a received byte is on rx_data |
| rx_data | output | 8 | Received byte |
| rx_done | output | 1 | One-cycle pulse: a receive transfer has ended |
| rx_done_count | output | RX_CNT_W | Bytes received in the transfer that ended |
| tx_valid | input | 1 | Transmit source has a byte ready |
| tx_data | input | 8 | Byte offered for transmission |
| tx_ready | output | 1 | One-cycle pulse: tx_data taken |
| tx_done | output | 1 | One-cycle pulse: a transmit transfer has ended |
| tx_done_count | output | TX_CNT_W | Bytes acknowledged by the bus controller |

## Verification
The address stage gets four patterns: a matching write, a matching read, a foreign address and the all-zero byte. Together they separate the acknowledge decision for direction from the one for general call and for no match. Reads run with three bytes in the source, one byte and none. These tell apart a master NACK at the end, the release of the line when the source runs dry, and a refusal at the address. Writes run from two bytes up to one past the buffer depth, with both a stop and a repeated start. These show when the done pulses fire and with what counts. A start with a stop right behind it checks the return to waiting.

// File: rtl/i2cs_pkg.sv
// Shared types for the I2C target controller.
package i2cs_pkg;

    // Protocol phases of the target state machine.
    typedef enum logic [2:0] {
        ST_WAIT    = 3'd0,  // idle, only start/stop are watched
        ST_ADDR    = 3'd1,  // shifting in the address byte
        ST_ACK_RD  = 3'd2,  // driving ACK for a read address
        ST_SEND    = 3'd3,  // shifting a byte out
        ST_GET_ACK = 3'd4,  // sampling the controller's ACK bit
        ST_ACK_GC  = 3'd5,  // driving ACK for a general call
        ST_ACK_WR  = 3'd6,  // driving ACK for a write address/byte
        ST_RECV    = 3'd7   // shifting a data byte in
    } state_t;

endpackage

// File: rtl/i2cs_line_sync.sv
// Multi-stage synchronizer for one bus line.
// Assumes the line idles high; resets to 1 so no false edges appear.
module i2cs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single flop: sample the line.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= d;
            end
        end else begin : g_multi
            // Shift chain: move the sample through the stages.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cs_bus_events.sv
// Turns synchronized SCL/SDA levels into single-cycle bus events:
// SCL rise/fall, start (SDA falls with SCL high over two samples)
// and stop (SDA rises with SCL high over two samples).
// Assumes inputs are already synchronized to clk.
module i2cs_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_q;
    logic sda_q;

    // Previous-sample registers for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_fsm.sv
// Byte-level target protocol engine. Samples data on SCL rise and changes
// its drive on SCL fall. It decides ACK/NACK for address and data bytes,
// moves bytes to/from the buffer handshakes and reports transfer counts.
// Assumes one event per cycle from i2cs_bus_events.
module i2cs_fsm
    import i2cs_pkg::*;
#(
    parameter logic [6:0] OWN_ADDR = 7'h42,
    parameter int RX_DEPTH = 25,
    parameter int TX_CNT_W = 8,
    parameter int RX_CNT_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sda_s,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                start_ev,
    input  logic                stop_ev,
    input  logic                tx_valid,
    input  logic [7:0]          tx_data,
    output logic                tx_ready,
    output logic                tx_done,
    output logic [TX_CNT_W-1:0] tx_done_count,
    output logic                rx_valid,
    output logic [7:0]          rx_data,
    output logic                rx_done,
    output logic [RX_CNT_W-1:0] rx_done_count,
    output logic                sda_oe
);
    localparam logic [RX_CNT_W-1:0] RX_LIM   = RX_CNT_W'(RX_DEPTH);
    localparam logic [3:0]          BYTE_END = 4'd8;

    state_t              state;
    logic [7:0]          shreg;
    logic [3:0]          bitcnt;
    logic                ack_n;
    logic [RX_CNT_W-1:0] rx_cnt;
    logic [TX_CNT_W-1:0] tx_cnt;

    // Protocol sequencing, drive control and transfer bookkeeping.
    always_ff @(posedge clk) begin
        rx_valid <= 1'b0;
        tx_ready <= 1'b0;
        rx_done  <= 1'b0;
        tx_done  <= 1'b0;
        if (!rst_n) begin
            state         <= ST_WAIT;
            shreg         <= '0;
            bitcnt        <= '0;
            ack_n         <= 1'b1;
            sda_oe        <= 1'b0;
            rx_data       <= '0;
            rx_cnt        <= '0;
            tx_cnt        <= '0;
            rx_done_count <= '0;
            tx_done_count <= '0;
        end else if (start_ev || stop_ev) begin
            if (rx_cnt != '0) begin
                rx_done       <= 1'b1;
                rx_done_count <= rx_cnt;
            end
            if (tx_cnt != '0) begin
                tx_done       <= 1'b1;
                tx_done_count <= tx_cnt;
            end
            rx_cnt <= '0;
            tx_cnt <= '0;
            sda_oe <= 1'b0;
            bitcnt <= '0;
            state  <= start_ev ? ST_ADDR : ST_WAIT;
        end else begin
            case (state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall && bitcnt == BYTE_END) begin
                        bitcnt <= '0;
                        if (shreg == 8'h00) begin
                            sda_oe <= 1'b1;
                            state  <= ST_ACK_GC;
                        end else if (shreg[7:1] == OWN_ADDR) begin
                            if (!shreg[0]) begin
                                sda_oe <= 1'b1;
                                state  <= ST_ACK_WR;
                            end else if (tx_valid) begin
                                shreg    <= tx_data;
                                tx_ready <= 1'b1;
                                sda_oe   <= 1'b1;
                                state    <= ST_ACK_RD;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                ST_ACK_GC: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_WAIT;
                    end
                end
                ST_ACK_WR: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        state  <= ST_RECV;
                    end
                end
                ST_RECV: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall && bitcnt == BYTE_END) begin
                        bitcnt <= '0;
                        if (rx_cnt < RX_LIM) begin
                            rx_valid <= 1'b1;
                            rx_data  <= shreg;
                            rx_cnt   <= rx_cnt + 1'b1;
                            sda_oe   <= 1'b1;
                            state    <= ST_ACK_WR;
                        end else begin
                            rx_done       <= 1'b1;
                            rx_done_count <= rx_cnt;
                            rx_cnt        <= '0;
                            state         <= ST_WAIT;
                        end
                    end
                end
                ST_ACK_RD: begin
                    if (scl_fall) begin
                        sda_oe <= ~shreg[7];
                        bitcnt <= '0;
                        state  <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (bitcnt == BYTE_END) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= ST_GET_ACK;
                        end else begin
                            sda_oe <= ~shreg[6];
                            shreg  <= {shreg[6:0], 1'b1};
                        end
                    end
                end
                ST_GET_ACK: begin
                    if (scl_rise) begin
                        ack_n <= sda_s;
                    end else if (scl_fall) begin
                        if (!ack_n) begin
                            tx_cnt <= tx_cnt + 1'b1;
                            if (tx_valid) begin
                                shreg    <= tx_data;
                                tx_ready <= 1'b1;
                                sda_oe   <= ~tx_data[7];
                                state    <= ST_SEND;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end else begin
                            if (tx_cnt != '0) begin
                                tx_done       <= 1'b1;
                                tx_done_count <= tx_cnt;
                            end
                            tx_cnt <= '0;
                            state  <= ST_WAIT;
                        end
                    end
                end
                default: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/i2c_target_ctrl.sv
// I2C target controller top: synchronizes both bus lines, derives bus
// events and runs the byte protocol engine. Assumes the system clock is
// well above the bus clock (at least 8 clk cycles per SCL phase).
module i2c_target_ctrl #(
    parameter logic [6:0] OWN_ADDR    = 7'h42,
    parameter int         RX_DEPTH    = 25,
    parameter int         TX_CNT_W    = 8,
    parameter int         SYNC_STAGES = 2,
    localparam int        RX_CNT_W    = $clog2(RX_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe,
    output logic                rx_valid,
    output logic [7:0]          rx_data,
    output logic                rx_done,
    output logic [RX_CNT_W-1:0] rx_done_count,
    input  logic                tx_valid,
    input  logic [7:0]          tx_data,
    output logic                tx_ready,
    output logic                tx_done,
    output logic [TX_CNT_W-1:0] tx_done_count
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] sync_lines;
    logic scl_rise, scl_fall, start_ev, stop_ev;

    assign raw_lines = {scl_i, sda_i};

    generate
        for (genvar g = 0; g < N_LINES; g++) begin : g_sync
            i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (raw_lines[g]),
                .q     (sync_lines[g])
            );
        end
    endgenerate

    i2cs_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (sync_lines[1]),
        .sda_s    (sync_lines[0]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2cs_fsm #(
        .OWN_ADDR (OWN_ADDR),
        .RX_DEPTH (RX_DEPTH),
        .TX_CNT_W (TX_CNT_W),
        .RX_CNT_W (RX_CNT_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .sda_s         (sync_lines[0]),
        .scl_rise      (scl_rise),
        .scl_fall      (scl_fall),
        .start_ev      (start_ev),
        .stop_ev       (stop_ev),
        .tx_valid      (tx_valid),
        .tx_data       (tx_data),
        .tx_ready      (tx_ready),
        .tx_done       (tx_done),
        .tx_done_count (tx_done_count),
        .rx_valid      (rx_valid),
        .rx_data       (rx_data),
        .rx_done       (rx_done),
        .rx_done_count (rx_done_count),
        .sda_oe        (sda_oe)
    );
endmodule

// File: rtl/i2c_target_ctrl_chk.sv
// Property checker for i2c_target_ctrl, attached by bind below.
module i2c_target_ctrl_chk #(
    parameter int RX_DEPTH = 25,
    parameter int RX_CNT_W = 5,
    parameter int TX_CNT_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sda_oe,
    input logic                scl_fall,
    input logic                start_ev,
    input logic                stop_ev,
    input logic                rx_valid,
    input logic                tx_ready,
    input logic                rx_done,
    input logic [RX_CNT_W-1:0] rx_done_count,
    input logic                tx_done,
    input logic [TX_CNT_W-1:0] tx_done_count
);
    localparam logic [RX_CNT_W-1:0] RX_LIM = RX_CNT_W'(RX_DEPTH);

    AST_OE_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start_ev || stop_ev)); // R12
    AST_RX_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R2
    AST_TX_SINGLE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |=> !tx_ready); // R5
    AST_RX_DONE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> (rx_done_count != '0 && rx_done_count <= RX_LIM)); // R9
    AST_TX_DONE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> tx_done_count != '0); // R8
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe); // R11
endmodule

bind i2c_target_ctrl i2c_target_ctrl_chk #(
    .RX_DEPTH (RX_DEPTH),
    .RX_CNT_W (RX_CNT_W),
    .TX_CNT_W (TX_CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sda_oe        (sda_oe),
    .scl_fall      (scl_fall),
    .start_ev      (start_ev),
    .stop_ev       (stop_ev),
    .rx_valid      (rx_valid),
    .tx_ready      (tx_ready),
    .rx_done       (rx_done),
    .rx_done_count (rx_done_count),
    .tx_done       (tx_done),
    .tx_done_count (tx_done_count)
);

// File: tb/i2c_target_ctrl_tb.sv
// Directed bench: a bit-level bus controller model drives SCL/SDA,
// a monitor logs the handshakes, one task per scenario checks results.
module i2c_target_ctrl_tb;
    localparam int Q        = 8;
    localparam int RX_DEPTH = 25;
    localparam int RX_CNT_W = $clog2(RX_DEPTH + 1);
    localparam int TX_CNT_W = 8;
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe, rx_valid, rx_done, tx_valid, tx_ready, tx_done;
    logic [7:0] rx_data, tx_data;
    logic [RX_CNT_W-1:0] rx_done_count;
    logic [TX_CNT_W-1:0] tx_done_count;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Monitor-owned counters and logs.
    int rx_n = 0, tx_taken = 0, rxd_n = 0, txd_n = 0, oe_cnt = 0, viol = 0;
    int rxd_last = 0, txd_last = 0;
    logic [7:0] rx_log [64];
    logic [3:0] scl_hist = 4'hF;
    logic oe_prev = 1'b0;

    // Task-owned transmit source setup.
    logic [7:0] tx_mem [8];
    int tx_base = 0, tx_avail = 0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign tx_valid = (tx_taken - tx_base) < tx_avail;
    assign tx_data  = tx_mem[(tx_taken - tx_base) & 7];

    i2c_target_ctrl #(.RX_DEPTH(RX_DEPTH), .TX_CNT_W(TX_CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_done(rx_done), .rx_done_count(rx_done_count),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .tx_done(tx_done), .tx_done_count(tx_done_count)
    );

    // Monitor: samples outputs on the falling clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin rx_log[rx_n & 63] = rx_data; rx_n++; end
            if (tx_ready) tx_taken++;
            if (rx_done) begin rxd_n++; rxd_last = int'(rx_done_count); end
            if (tx_done) begin txd_n++; txd_last = int'(tx_done_count); end
            if (sda_oe) oe_cnt++;
            if (sda_oe != oe_prev && scl_m && scl_hist == 4'hF) viol++;
        end
        oe_prev  = sda_oe;
        scl_hist = {scl_hist[2:0], scl_m};
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_bit(input logic b, output logic seen);
        sda_m = b;    wq(Q);
        scl_m = 1'b1; wq(Q);
        seen = sda_line; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2 * Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
        bus_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic rd_byte(input logic ack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s);
            d[i] = s;
        end
        bus_bit(~ack, s);
    endtask

    task automatic t_reset;
        wq(4);
        chk("R1 sda_oe in reset", int'(sda_oe), 0);
        chk("R1 strobes in reset", int'({rx_valid, tx_ready, rx_done, tx_done}), 0);
        rst_n = 1'b1;
        wq(4);
        chk("R1 sda_oe after reset", int'(sda_oe), 0);
    endtask

    task automatic t_write;
        int r0 = rx_n, d0 = rxd_n;
        logic a;
        bus_start;
        wr_byte(8'h84, a); chk("R2 write address ack", int'(a), 1);
        wr_byte(8'hA5, a); chk("R2 data byte 1 ack", int'(a), 1);
        wr_byte(8'h3C, a); chk("R2 data byte 2 ack", int'(a), 1);
        chk("R2 bytes received", rx_n - r0, 2);
        chk("R2 first byte value", int'(rx_log[r0 & 63]), 8'hA5);
        chk("R2 second byte value", int'(rx_log[(r0 + 1) & 63]), 8'h3C);
        bus_stop;
        chk("R10 rx_done at stop", rxd_n - d0, 1);
        chk("R10 rx_done_count at stop", rxd_last, 2);
    endtask

    task automatic t_foreign;
        int o0 = oe_cnt, r0 = rx_n;
        logic a;
        bus_start;
        wr_byte(8'h90, a); chk("R3 foreign address nack", int'(a), 0);
        wr_byte(8'h11, a); chk("R3 later byte nack", int'(a), 0);
        bus_stop;
        chk("R3 line never driven", oe_cnt - o0, 0);
        chk("R3 nothing received", rx_n - r0, 0);
    endtask

    task automatic t_gcall;
        int r0 = rx_n;
        logic a;
        bus_start;
        wr_byte(8'h00, a); chk("R4 general call ack", int'(a), 1);
        wr_byte(8'h55, a); chk("R4 byte after general call nack", int'(a), 0);
        bus_stop;
        chk("R4 no rx_valid", rx_n - r0, 0);
    endtask

    task automatic t_read_nack;
        int d0 = txd_n, k0 = tx_taken;
        logic a;
        logic [7:0] v;
        tx_mem[0] = 8'hC3; tx_mem[1] = 8'h5A; tx_mem[2] = 8'h81;
        tx_base = tx_taken; tx_avail = 3;
        bus_start;
        wr_byte(8'h85, a); chk("R5 read address ack", int'(a), 1);
        rd_byte(1'b1, v);  chk("R5 read byte 1", int'(v), 8'hC3);
        rd_byte(1'b1, v);  chk("R7 read byte 2", int'(v), 8'h5A);
        rd_byte(1'b0, v);  chk("R7 read byte 3", int'(v), 8'h81);
        chk("R8 tx_done on nack", txd_n - d0, 1);
        chk("R8 tx_done_count", txd_last, 2);
        bus_stop;
        chk("R8 no second tx_done", txd_n - d0, 1);
        chk("R5 bytes taken", tx_taken - k0, 3);
        tx_avail = 0;
    endtask

    task automatic t_read_drain;
        int d0 = txd_n;
        logic a;
        logic [7:0] v;
        tx_mem[0] = 8'h6E;
        tx_base = tx_taken; tx_avail = 1;
        bus_start;
        wr_byte(8'h85, a); chk("R5 read address ack (1 byte)", int'(a), 1);
        rd_byte(1'b1, v);  chk("R5 single byte", int'(v), 8'h6E);
        rd_byte(1'b0, v);  chk("R7 released line reads FF", int'(v), 8'hFF);
        bus_stop;
        chk("R10 tx_done at stop", txd_n - d0, 1);
        chk("R10 tx_done_count at stop", txd_last, 1);
        tx_avail = 0;
    endtask

    task automatic t_read_empty;
        int k0 = tx_taken;
        logic a;
        tx_base = tx_taken; tx_avail = 0;
        bus_start;
        wr_byte(8'h85, a); chk("R6 read address nack when empty", int'(a), 0);
        bus_stop;
        chk("R6 no byte taken", tx_taken - k0, 0);
    endtask

    task automatic t_full;
        int r0 = rx_n, d0 = rxd_n, nacks = 0;
        logic a;
        bus_start;
        wr_byte(8'h84, a); chk("R9 write address ack", int'(a), 1);
        for (int i = 0; i < RX_DEPTH; i++) begin
            wr_byte(8'(i + 1), a);
            if (!a) nacks++;
        end
        chk("R9 bytes within depth acked", nacks, 0);
        wr_byte(8'hEE, a); chk("R9 byte past depth nack", int'(a), 0);
        chk("R9 received count", rx_n - r0, RX_DEPTH);
        chk("R9 rx_done on overflow", rxd_n - d0, 1);
        chk("R9 rx_done_count", rxd_last, RX_DEPTH);
        bus_stop;
        chk("R9 no extra rx_done", rxd_n - d0, 1);
    endtask

    task automatic t_restart;
        int d0 = rxd_n;
        logic a;
        bus_start;
        wr_byte(8'h84, a);
        wr_byte(8'h77, a);
        bus_start;
        chk("R10 rx_done at repeated start", rxd_n - d0, 1);
        chk("R10 count at repeated start", rxd_last, 1);
        wr_byte(8'h84, a); chk("R10 address after repeated start", int'(a), 1);
        wr_byte(8'h12, a);
        bus_stop;
        chk("R10 second close-out", rxd_n - d0, 2);
    endtask

    task automatic t_imm_stop;
        int o0 = oe_cnt;
        logic a;
        bus_start;
        bus_stop;
        chk("R11 no drive on start+stop", oe_cnt - o0, 0);
        bus_start;
        wr_byte(8'h84, a); chk("R11 next address handled", int'(a), 1);
        bus_stop;
    endtask

    initial begin
        t_reset;
        t_write;
        t_foreign;
        t_gcall;
        t_read_nack;
        t_read_drain;
        t_read_empty;
        t_full;
        t_restart;
        t_imm_stop;
        chk("R12 sda_oe stable while SCL high", viol, 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule